// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block owns three shared control registers for a group of switchable power domains. The power register works active-high: a set bit holds a domain unpowered. The isolation register works active-low: a cleared bit keeps its isolation cells clamped. The reset register also works active-low: a cleared bit holds a unit in reset.

Each domain has three masks, one per register, fixed by parameters. A requester asks for a domain to be switched on or off using a valid/ready handshake that carries a domain index and a direction. The block then walks through three steps in a fixed order:

- **On:** power first, then reset, then isolation.
- **Off:** the reverse order.

Each step read-modify-writes only the selected domain's bits. A step whose mask is zero is skipped, except the power step, which always runs. After each write the block waits a programmable number of settle cycles before starting the next step. While the sequencer is idle, a simple register port can overwrite any of the three registers. A per-domain status vector reports which domains are powered.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the three registers hold their parameter initial values (defaults: power 0x00000004, isolation 0x00000001, reset 0x00010000), `req_ready` is 1, `busy` is 0 and `seq_done` is 0.
- R2: A power-on request changes the registers in this order, one register per change event: clear the domain's power bits, then set its reset bits, then set its isolation bits.
- R3: A power-off request changes the registers in this order: clear the domain's isolation bits, then clear its reset bits, then set its power bits.
- R4: A step whose isolation or reset mask is zero makes no change and is skipped. The power step is always performed. Default domain 2 has power mask 0x1 and zero isolation and reset masks.
- R5: A sequence changes only bits inside the selected domain's masks. Every other bit of all three registers is kept. Default masks: domain 0 has power 0x8, isolation 0x1, reset 0x00010000; domain 1 has power 0x4, isolation 0x2, reset 0x00040000.
- R6: Two consecutive register changes within one sequence are at least `settle_cycles`+1 clock cycles apart, and no cycle changes more than one register.
- R7: `req_ready` is 1 only while idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. A request raised while a sequence runs waits until that sequence ends. `seq_done` is a one-cycle pulse when a sequence ends.
- R8: A port write (`cfg_we`=1; `cfg_sel` 0 = power, 1 = isolation, 2 = reset, 3 = none) takes effect on the next edge when the block is idle. The write is ignored while a sequence runs. It is also dropped when a request is accepted in the same cycle.
- R9: `dom_on[i]` is 1 exactly when none of domain i's power-mask bits are set in the power register.
- R10: A request whose index is not below the domain count completes with a `seq_done` pulse and leaves all three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| settle_cycles | input | CW | Extra wait cycles after each control change |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dom | input | IW | Domain index of the request |
| req_on | input | 1 | 1 = power on, 0 = power off |
| seq_done | output | 1 | One-cycle pulse when a sequence ends |
| cfg_we | input | 1 | Register port write strobe |
| cfg_sel | input | 2 | Register select: 0 power, 1 isolation, 2 reset, 3 none |
| cfg_wdata | input | RW | Register port write data |
| pwr_ctl | output | RW | Power register, set bit = powered down |
| iso_ctl | output | RW | Isolation register, cleared bit = isolated |
| rst_ctl | output | RW | Reset register, cleared bit = held in reset |
| dom_on | output | NDOM | Per-domain powered status |
| busy | output | 1 | A sequence is in progress |

## Verification
Power-on and power-off are both exercised on domains that use all three masks, with settle values of 0, 2 and 3. Recording every register change event shows whether the step order is right, whether the mask polarities are right, and whether the waits are long enough. The third domain has only a power mask, so it confirms that steps with empty masks are skipped rather than written as no-ops. An out-of-range index confirms that no register is touched. A request held high during a running sequence, a port write made while busy, and a port write made in the same cycle as an acceptance separate correct queueing and port blocking from premature starts and leaked writes.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    SEL_PWR  = 2'd0,
    SEL_ISO  = 2'd1,
    SEL_RST  = 2'd2,
    SEL_NONE = 2'd3
  } ctl_sel_e;

  // register written by step k of a sequence in the given direction
  function automatic ctl_sel_e step_target(input logic on, input logic [1:0] k);
    if (on) begin
      case (k)
        2'd0:    return SEL_PWR;
        2'd1:    return SEL_RST;
        default: return SEL_ISO;
      endcase
    end else begin
      case (k)
        2'd0:    return SEL_ISO;
        2'd1:    return SEL_RST;
        default: return SEL_PWR;
      endcase
    end
  endfunction

  // power bits are active-high "off"; reset and isolation are active-low
  function automatic logic step_sets(input logic on, input ctl_sel_e t);
    return on ^ (t == SEL_PWR);
  endfunction
endpackage

// File: rtl/pds_step_ctrl.sv
module pds_step_ctrl #(
  parameter int CW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] settle,
  input  logic          req_valid,
  input  logic [IW-1:0] req_dom,
  input  logic          req_on,
  input  logic          step_skip,
  output logic          req_ready,
  output logic          accept,
  output logic          busy,
  output logic          step_we,
  output logic [1:0]    step_k,
  output logic          dir_q,
  output logic [IW-1:0] dom_q,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT} st_e;
  localparam logic [1:0] LAST_K = 2'd2;

  st_e           st;
  logic [CW-1:0] cnt;

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign accept    = req_ready && req_valid;
  assign step_we   = (st == S_STEP) && !step_skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step_k <= 2'd0;
      cnt    <= '0;
      dir_q  <= 1'b0;
      dom_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_STEP;
          step_k <= 2'd0;
          dom_q  <= req_dom;
          dir_q  <= req_on;
        end
        S_STEP: if (step_skip) begin
          if (step_k == LAST_K) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            step_k <= step_k + 2'd1;
          end
        end else begin
          cnt <= settle;
          st  <= S_WAIT;
        end
        S_WAIT: if (cnt == '0) begin
          if (step_k == LAST_K) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            step_k <= step_k + 2'd1;
            st     <= S_STEP;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pds_ctrl_regs.sv
module pds_ctrl_regs import pds_pkg::*; #(
  parameter int RW = 32,
  parameter logic [RW-1:0] PWR_INIT = '0,
  parameter logic [RW-1:0] ISO_INIT = '0,
  parameter logic [RW-1:0] RST_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_we,
  input  ctl_sel_e      seq_target,
  input  logic [RW-1:0] seq_mask,
  input  logic          seq_set,
  input  logic          port_we,
  input  ctl_sel_e      port_sel,
  input  logic [RW-1:0] port_wdata,
  output logic [RW-1:0] pwr_q,
  output logic [RW-1:0] iso_q,
  output logic [RW-1:0] rst_q
);
  function automatic logic [RW-1:0] upd(input logic [RW-1:0] cur,
                                        input logic [RW-1:0] mask,
                                        input logic set);
    return set ? (cur | mask) : (cur & ~mask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PWR_INIT;
      iso_q <= ISO_INIT;
      rst_q <= RST_INIT;
    end else if (seq_we) begin
      case (seq_target)
        SEL_PWR: pwr_q <= upd(pwr_q, seq_mask, seq_set);
        SEL_ISO: iso_q <= upd(iso_q, seq_mask, seq_set);
        SEL_RST: rst_q <= upd(rst_q, seq_mask, seq_set);
        default: ;
      endcase
    end else if (port_we) begin
      case (port_sel)
        SEL_PWR: pwr_q <= port_wdata;
        SEL_ISO: iso_q <= port_wdata;
        SEL_RST: rst_q <= port_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pds_dom_status.sv
module pds_dom_status #(
  parameter int NDOM = 3,
  parameter int RW   = 32,
  parameter logic [NDOM*RW-1:0] PWR_MASKS = '0
) (
  input  logic [RW-1:0]   pwr,
  output logic [NDOM-1:0] dom_on
);
  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    assign dom_on[g] = ~|(pwr & PWR_MASKS[g*RW +: RW]);
  end
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq import pds_pkg::*; #(
  parameter int NDOM = 3,
  parameter int RW   = 32,
  parameter int CW   = 8,
  parameter logic [NDOM*RW-1:0] PWR_MASKS = {32'h0000_0001, 32'h0000_0004, 32'h0000_0008},
  parameter logic [NDOM*RW-1:0] ISO_MASKS = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001},
  parameter logic [NDOM*RW-1:0] RST_MASKS = {32'h0000_0000, 32'h0004_0000, 32'h0001_0000},
  parameter logic [RW-1:0] PWR_INIT = 32'h0000_0004,
  parameter logic [RW-1:0] ISO_INIT = 32'h0000_0001,
  parameter logic [RW-1:0] RST_INIT = 32'h0001_0000,
  localparam int IW = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   settle_cycles,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [IW-1:0]   req_dom,
  input  logic            req_on,
  output logic            seq_done,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [RW-1:0]   cfg_wdata,
  output logic [RW-1:0]   pwr_ctl,
  output logic [RW-1:0]   iso_ctl,
  output logic [RW-1:0]   rst_ctl,
  output logic [NDOM-1:0] dom_on,
  output logic            busy
);
  logic          accept, seq_we, dir_q, cur_skip, cur_set, cfg_taken;
  logic [1:0]    step_k;
  logic [IW-1:0] dom_q;
  logic [RW-1:0] sel_pm, sel_im, sel_rm, cur_mask;
  ctl_sel_e      target;

  pds_step_ctrl #(.CW(CW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .settle(settle_cycles),
    .req_valid(req_valid), .req_dom(req_dom), .req_on(req_on),
    .step_skip(cur_skip), .req_ready(req_ready), .accept(accept),
    .busy(busy), .step_we(seq_we), .step_k(step_k), .dir_q(dir_q),
    .dom_q(dom_q), .done(seq_done)
  );

  // masks of the latched domain; an out-of-range index selects empty masks
  always_comb begin
    sel_pm = '0;
    sel_im = '0;
    sel_rm = '0;
    for (int i = 0; i < NDOM; i++) begin
      if (dom_q == IW'(i)) begin
        sel_pm = PWR_MASKS[i*RW +: RW];
        sel_im = ISO_MASKS[i*RW +: RW];
        sel_rm = RST_MASKS[i*RW +: RW];
      end
    end
  end

  assign target = step_target(dir_q, step_k);
  assign cur_set = step_sets(dir_q, target);

  always_comb begin
    case (target)
      SEL_PWR: cur_mask = sel_pm;
      SEL_ISO: cur_mask = sel_im;
      SEL_RST: cur_mask = sel_rm;
      default: cur_mask = '0;
    endcase
  end

  assign cur_skip  = (target != SEL_PWR) && (cur_mask == '0);
  assign cfg_taken = cfg_we && !busy && !accept;

  pds_ctrl_regs #(.RW(RW), .PWR_INIT(PWR_INIT), .ISO_INIT(ISO_INIT), .RST_INIT(RST_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .seq_we(seq_we), .seq_target(target), .seq_mask(cur_mask), .seq_set(cur_set),
    .port_we(cfg_taken), .port_sel(ctl_sel_e'(cfg_sel)), .port_wdata(cfg_wdata),
    .pwr_q(pwr_ctl), .iso_q(iso_ctl), .rst_q(rst_ctl)
  );

  pds_dom_status #(.NDOM(NDOM), .RW(RW), .PWR_MASKS(PWR_MASKS)) u_stat (
    .pwr(pwr_ctl), .dom_on(dom_on)
  );
endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          accept,
  input logic          seq_we,
  input logic          seq_done,
  input logic          req_ready,
  input logic [RW-1:0] pwr_ctl,
  input logic [RW-1:0] iso_ctl,
  input logic [RW-1:0] rst_ctl,
  input logic [RW-1:0] sel_pm,
  input logic [RW-1:0] sel_im,
  input logic [RW-1:0] sel_rm
);
  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !req_ready));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_port_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_we) |=> ($stable(pwr_ctl) && $stable(iso_ctl) && $stable(rst_ctl)));

  assert_one_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones({!$stable(pwr_ctl), !$stable(iso_ctl), !$stable(rst_ctl)}) <= 1));

  assert_only_domain_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((((pwr_ctl ^ $past(pwr_ctl)) & ~$past(sel_pm)) == '0) &&
              (((iso_ctl ^ $past(iso_ctl)) & ~$past(sel_im)) == '0) &&
              (((rst_ctl ^ $past(rst_ctl)) & ~$past(sel_rm)) == '0)));
endmodule

bind pwr_dom_seq pwr_dom_seq_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .seq_we(seq_we),
  .seq_done(seq_done), .req_ready(req_ready), .pwr_ctl(pwr_ctl),
  .iso_ctl(iso_ctl), .rst_ctl(rst_ctl), .sel_pm(sel_pm), .sel_im(sel_im),
  .sel_rm(sel_rm)
);

// File: tb/pwr_dom_seq_test.sv
module pwr_dom_seq_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  settle_cycles = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_dom = '0;
  logic        req_on = 1'b0;
  logic        seq_done;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pwr_ctl, iso_ctl, rst_ctl;
  logic [2:0]  dom_on;
  logic        busy;

  always #(CLK_P/2) clk = ~clk;

  pwr_dom_seq uut (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_dom(req_dom),
    .req_on(req_on), .seq_done(seq_done), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pwr_ctl(pwr_ctl), .iso_ctl(iso_ctl),
    .rst_ctl(rst_ctl), .dom_on(dom_on), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench copy of the domain masks (index 3 = out of range, empty)
  logic [31:0] bpm [4] = '{32'h8, 32'h4, 32'h1, 32'h0};
  logic [31:0] bim [4] = '{32'h1, 32'h2, 32'h0, 32'h0};
  logic [31:0] brm [4] = '{32'h0001_0000, 32'h0004_0000, 32'h0, 32'h0};

  logic [31:0] m_pwr = 32'h4, m_iso = 32'h1, m_rst = 32'h0001_0000;

  int ev_sel [8];
  int ev_cyc [8];
  int nev;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_on(input logic [31:0] p);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = ((p & bpm[i]) == 32'h0);
    return r;
  endfunction

  task automatic model_apply(input int d, input bit on);
    if (on) begin
      m_pwr = m_pwr & ~bpm[d];
      m_rst = m_rst | brm[d];
      m_iso = m_iso | bim[d];
    end else begin
      m_iso = m_iso & ~bim[d];
      m_rst = m_rst & ~brm[d];
      m_pwr = m_pwr | bpm[d];
    end
  endtask

  task automatic run_seq(input int d, input bit on, input int st);
    logic [31:0] pp, ip, rp;
    int cyc;
    @(negedge clk);
    settle_cycles = 8'(st);
    req_valid = 1'b1; req_dom = 2'(d); req_on = on;
    while (!req_ready) @(negedge clk);
    pp = pwr_ctl; ip = iso_ctl; rp = rst_ctl;
    @(negedge clk);
    req_valid = 1'b0;
    nev = 0; cyc = 0;
    forever begin
      cyc++;
      if (pwr_ctl !== pp && nev < 8) begin ev_sel[nev] = 0; ev_cyc[nev] = cyc; nev++; pp = pwr_ctl; end
      if (iso_ctl !== ip && nev < 8) begin ev_sel[nev] = 1; ev_cyc[nev] = cyc; nev++; ip = iso_ctl; end
      if (rst_ctl !== rp && nev < 8) begin ev_sel[nev] = 2; ev_cyc[nev] = cyc; nev++; rp = rst_ctl; end
      if (seq_done || cyc > 3000) break;
      @(negedge clk);
    end
    chk(seq_done === 1'b1, "R7", "done pulse seen", 32'(seq_done), 32'h1);
  endtask

  // compare recorded events against the expected order, then final values
  task automatic check_seq(input string req, input int d, input bit on, input int st);
    int exp_sel [3];
    int ne = 0;
    if (on) begin
      exp_sel[ne] = 0; ne++;
      if (brm[d] != 0) begin exp_sel[ne] = 2; ne++; end
      if (bim[d] != 0) begin exp_sel[ne] = 1; ne++; end
    end else begin
      if (bim[d] != 0) begin exp_sel[ne] = 1; ne++; end
      if (brm[d] != 0) begin exp_sel[ne] = 2; ne++; end
      exp_sel[ne] = 0; ne++;
    end
    if (d == 3) ne = 0;
    chk(nev == ne, req, "number of change events", 32'(nev), 32'(ne));
    for (int i = 0; i < ne && i < nev; i++) begin
      chk(ev_sel[i] == exp_sel[i], req, "register changed at step", 32'(ev_sel[i]), 32'(exp_sel[i]));
      if (i > 0)
        chk(ev_cyc[i] - ev_cyc[i-1] >= st + 1, "R6", "gap between changes",
            32'(ev_cyc[i] - ev_cyc[i-1]), 32'(st + 1));
    end
    model_apply(d, on);
    chk(pwr_ctl === m_pwr, "R5", "power register", pwr_ctl, m_pwr);
    chk(iso_ctl === m_iso, "R5", "isolation register", iso_ctl, m_iso);
    chk(rst_ctl === m_rst, "R5", "reset register", rst_ctl, m_rst);
    chk(dom_on === exp_on(m_pwr), "R9", "domain status", 32'(dom_on), 32'(exp_on(m_pwr)));
  endtask

  task automatic t_reset;
    chk(pwr_ctl === 32'h4, "R1", "power init", pwr_ctl, 32'h4);
    chk(iso_ctl === 32'h1, "R1", "isolation init", iso_ctl, 32'h1);
    chk(rst_ctl === 32'h0001_0000, "R1", "reset init", rst_ctl, 32'h0001_0000);
    chk(req_ready === 1'b1 && busy === 1'b0 && seq_done === 1'b0, "R1", "idle flags",
        {29'h0, req_ready, busy, seq_done}, 32'h4);
    chk(dom_on === 3'b101, "R9", "status at reset", 32'(dom_on), 32'h5);
  endtask

  task automatic t_power_on;   // R2
    run_seq(1, 1'b1, 2);
    check_seq("R2", 1, 1'b1, 2);
  endtask

  task automatic t_power_off;  // R3
    run_seq(0, 1'b0, 0);
    check_seq("R3", 0, 1'b0, 0);
  endtask

  task automatic t_skip;       // R4
    run_seq(2, 1'b0, 1);
    check_seq("R4", 2, 1'b0, 1);
    run_seq(2, 1'b1, 1);
    check_seq("R4", 2, 1'b1, 1);
  endtask

  task automatic t_out_of_range;  // R10
    run_seq(3, 1'b1, 3);
    check_seq("R10", 3, 1'b1, 3);
  endtask

  task automatic t_held;       // R7
    int guard = 0;
    @(negedge clk);
    settle_cycles = 8'd3;
    req_valid = 1'b1; req_dom = 2'd0; req_on = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_dom = 2'd1; req_on = 1'b0;   // second request held high
    chk(req_ready === 1'b0, "R7", "ready low while busy", 32'(req_ready), 32'h0);
    while (!seq_done && guard < 3000) begin @(negedge clk); guard++; end
    model_apply(0, 1'b1);
    chk(pwr_ctl === m_pwr, "R7", "held request not started early", pwr_ctl, m_pwr);
    chk(iso_ctl === m_iso, "R7", "first sequence isolation", iso_ctl, m_iso);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R7", "held request accepted after done", 32'(busy), 32'h1);
    guard = 0;
    while (!seq_done && guard < 3000) begin @(negedge clk); guard++; end
    model_apply(1, 1'b0);
    chk(pwr_ctl === m_pwr && iso_ctl === m_iso && rst_ctl === m_rst, "R7",
        "held request result", pwr_ctl, m_pwr);
  endtask

  task automatic t_port;       // R8
    int guard = 0;
    // idle write lands
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = m_pwr | 32'h100;
    @(negedge clk);
    cfg_we = 1'b0;
    m_pwr = m_pwr | 32'h100;
    chk(pwr_ctl === m_pwr, "R8", "idle write", pwr_ctl, m_pwr);
    // write while busy is ignored
    settle_cycles = 8'd4;
    req_valid = 1'b1; req_dom = 2'd1; req_on = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'hDEAD_0000;
    repeat (3) @(negedge clk);
    cfg_we = 1'b0;
    while (!seq_done && guard < 3000) begin @(negedge clk); guard++; end
    model_apply(1, 1'b1);
    chk(iso_ctl === m_iso, "R8", "busy write ignored", iso_ctl, m_iso);
    // write in the same cycle as an accepted request is dropped
    @(negedge clk);
    settle_cycles = 8'd0;
    req_valid = 1'b1; req_dom = 2'd0; req_on = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    guard = 0;
    while (!seq_done && guard < 3000) begin @(negedge clk); guard++; end
    model_apply(0, 1'b0);
    chk(rst_ctl === m_rst, "R8", "write with accept dropped", rst_ctl, m_rst);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_on();
    t_power_off();
    t_skip();
    t_out_of_range();
    t_held();
    t_port();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule